// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control state machine of a small 16-bit processor with eight general registers. It watches the contents of the instruction register and, in every cycle, drives the strobes the datapath needs. These strobes are the program-counter clear and step, the program-memory read, the instruction-register load, an immediate value, the data-memory address select and write enable, the register-file write-source select, the three register indices with a write enable, and a 4-bit ALU operation code.

Execution walks through a reset state, then fetch and decode, then exactly one execute state for the instruction class. The register file, ALU and memories sit outside the block. No data stream passes through the block, so it has no valid/ready handshake. Every pin is a plain level control signal. Outputs are combinational functions of the current state and the instruction word. The state advances on each rising clock edge and is never stalled.

The instruction word is split into fields as follows:

| Field | Bits |
|-------|------|
| opcode | 15..12 |
| form flag (1 = immediate) | 11 |
| destination index | 10..8 |
| first source index | 7..5 |
| second source index | 4..2 |

Top module: `cpu_ctrl_fsm`

## Requirements
- R1: While `rst_n` is low the state is init (code 0000). In init only `pc_clear` is 1, and every other output is 0. The cycle after reset is released, the state is fetch.
- R2: In fetch (code 0001), `pc_step`, `rom_rd` and `ir_load` are 1 and all other outputs are 0. The next state is always decode.
- R3: In decode (code 0011), every output except `state_code` is 0, including `imm_val`. The execute state codes are:

| Execute state | Code |
|---------------|------|
| halt | 0100 |
| move | 0101 |
| load | 0110 |
| store | 0111 |
| ALU | 1000 |

- R4: Decode branches on the opcode in bits 15..12 as follows:

| Opcode | Next state |
|--------|------------|
| 0000 | fetch |
| 1111 | halt |
| 0001 | move |
| 0010 | store |
| 0011 | load |
| 0100 to 1010 | ALU |
| 1011 to 1110 | fetch |

- R5: In halt every output except `state_code` is 0. The state stays in halt until reset.
- R6: Move with bit 11 = 1 gives `rf_src`=10 and `rd_wr`=1, with `rd_idx` taken from bits 10..8. `imm_val` is bits 7..0 zero-extended, and `rm_idx`=`rn_idx`=000.
- R7: Move with bit 11 = 0 gives `rf_src`=00 and `rd_wr`=1, with `rd_idx` from bits 10..8 and `rm_idx` from bits 7..5. `imm_val`=0 and `rn_idx`=000.
- R8: In load, `rf_src`=01 and `rd_wr`=1, with `rd_idx` from bits 10..8 and `rm_idx` from bits 7..5. `rn_idx`=000 and `imm_val`=0, and bit 11 is ignored.
- R9: Store with bit 11 = 1 gives `ram_wr`=1, `ram_addr_sel`=1 and `rd_wr`=0, with `rm_idx` from bits 7..5. `imm_val` is zero-extended {bits 10..8, bits 4..0}, and `rd_idx`=`rn_idx`=000.
- R10: Store with bit 11 = 0 gives `ram_wr`=1 and `ram_addr_sel`=0, with `rm_idx` from bits 7..5 and `rn_idx` from bits 4..2. `imm_val`=0 and `rd_idx`=000.
- R11: In the ALU state, `rf_src`=11 and `rd_wr`=1, and `alu_op` equals bits 15..12. The index fields are decoded as usual, and `imm_val`=0. `alu_op` is 0000 in every other state.
- R12: From move, load, store and ALU the next state is fetch, after exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 16 | Instruction register contents |
| state_code | output | 4 | Current state encoding |
| pc_clear | output | 1 | Clear program counter |
| pc_step | output | 1 | Increment program counter |
| rom_rd | output | 1 | Program memory read enable |
| ir_load | output | 1 | Instruction register load |
| imm_val | output | 16 | Immediate value to the datapath |
| ram_addr_sel | output | 1 | Data memory select (1 = immediate form) |
| ram_wr | output | 1 | Data memory write enable |
| rf_src | output | 2 | Register write source: 00 reg, 01 RAM, 10 imm, 11 ALU |
| rd_idx | output | 3 | Destination register index |
| rd_wr | output | 1 | Register file write enable |
| rm_idx | output | 3 | First source register index |
| rn_idx | output | 3 | Second source register index |
| alu_op | output | 4 | ALU operation code |

## Verification
All outputs are combinational from the registered state, so each result is valid in the same cycle the state is entered. With reset released before a rising edge, fetch appears one edge later and decode two edges later. The execute state appears three edges later, and the state after execute appears four edges later. The bench changes inputs and samples all outputs only at falling edges, one falling edge per state step. It sweeps every opcode, both forms and several field patterns, and compares the full output vector against a value built from the requirement for the state it expects at that step.

// File: rtl/cpu_ctrl_pkg.sv
package cpu_ctrl_pkg;

  typedef enum logic [3:0] {
    ST_INIT   = 4'b0000,
    ST_FETCH  = 4'b0001,
    ST_DECODE = 4'b0011,
    ST_HALT   = 4'b0100,
    ST_MOV    = 4'b0101,
    ST_LOAD   = 4'b0110,
    ST_STORE  = 4'b0111,
    ST_ALU    = 4'b1000
  } state_e;

  typedef enum logic [1:0] {
    SRC_REG = 2'b00,
    SRC_RAM = 2'b01,
    SRC_IMM = 2'b10,
    SRC_ALU = 2'b11
  } rf_src_e;

  localparam logic [3:0] OP_NOP    = 4'h0;
  localparam logic [3:0] OP_MOV    = 4'h1;
  localparam logic [3:0] OP_STR    = 4'h2;
  localparam logic [3:0] OP_LDR    = 4'h3;
  localparam logic [3:0] OP_ALU_LO = 4'h4;
  localparam logic [3:0] OP_ALU_HI = 4'hA;
  localparam logic [3:0] OP_HALT   = 4'hF;

  localparam int IDX_W  = 3;
  localparam int OP_W   = 4;
  localparam int IMM8_W = 8;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic              imm_form;
    logic [IDX_W-1:0]  rd;
    logic [IDX_W-1:0]  rm;
    logic [IDX_W-1:0]  rn;
    logic [IMM8_W-1:0] mov_imm;
    logic [IMM8_W-1:0] str_imm;
  } fields_t;

endpackage

// File: rtl/cpu_ctrl_fields.sv
module cpu_ctrl_fields
  import cpu_ctrl_pkg::*;
#(
  parameter int INSTR_W = 16
) (
  input  logic [INSTR_W-1:0] instr,
  output fields_t            flds
);
  localparam int OP_LSB = INSTR_W - OP_W;
  localparam int FORM_B = OP_LSB - 1;

  always_comb begin
    flds.op       = instr[INSTR_W-1:OP_LSB];
    flds.imm_form = instr[FORM_B];
    flds.rd       = instr[10:8];
    flds.rm       = instr[7:5];
    flds.rn       = instr[4:2];
    flds.mov_imm  = instr[7:0];
    // immediate store splits its constant around the address field
    flds.str_imm  = {instr[10:8], instr[4:0]};
  end
endmodule

// File: rtl/cpu_ctrl_next.sv
module cpu_ctrl_next
  import cpu_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op,
  output state_e          state
);
  state_e nxt;

  always_comb begin
    nxt = ST_FETCH;
    unique case (state)
      ST_INIT:   nxt = ST_FETCH;
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        if (op == OP_HALT)                           nxt = ST_HALT;
        else if (op == OP_MOV)                       nxt = ST_MOV;
        else if (op == OP_STR)                       nxt = ST_STORE;
        else if (op == OP_LDR)                       nxt = ST_LOAD;
        else if (op >= OP_ALU_LO && op <= OP_ALU_HI) nxt = ST_ALU;
        else                                         nxt = ST_FETCH;
      end
      ST_HALT:   nxt = ST_HALT;
      default:   nxt = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_INIT;
    else        state <= nxt;
  end

  // R1
  init_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_INIT |=> state == ST_FETCH);
  // R2
  fetch_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_FETCH |=> state == ST_DECODE);
  // R5
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_HALT |=> state == ST_HALT);
  // R12
  exec_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MOV || state == ST_LOAD || state == ST_STORE || state == ST_ALU)
    |=> state == ST_FETCH);
endmodule

// File: rtl/cpu_ctrl_outputs.sv
module cpu_ctrl_outputs
  import cpu_ctrl_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  state_e            state,
  input  fields_t           flds,
  output logic              pc_clear,
  output logic              pc_step,
  output logic              rom_rd,
  output logic              ir_load,
  output logic [DATA_W-1:0] imm_val,
  output logic              ram_addr_sel,
  output logic              ram_wr,
  output logic [1:0]        rf_src,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              rd_wr,
  output logic [IDX_W-1:0]  rm_idx,
  output logic [IDX_W-1:0]  rn_idx,
  output logic [OP_W-1:0]   alu_op
);
  localparam int PAD_W = DATA_W - IMM8_W;

  logic [DATA_W-1:0] mov_ext, str_ext;
  assign mov_ext = {{PAD_W{1'b0}}, flds.mov_imm};
  assign str_ext = {{PAD_W{1'b0}}, flds.str_imm};

  always_comb begin
    pc_clear     = 1'b0;
    pc_step      = 1'b0;
    rom_rd       = 1'b0;
    ir_load      = 1'b0;
    imm_val      = '0;
    ram_addr_sel = 1'b0;
    ram_wr       = 1'b0;
    rf_src       = SRC_REG;
    rd_idx       = '0;
    rd_wr        = 1'b0;
    rm_idx       = '0;
    rn_idx       = '0;
    alu_op       = '0;
    unique case (state)
      ST_INIT:  pc_clear = 1'b1;
      ST_FETCH: begin
        pc_step = 1'b1;
        rom_rd  = 1'b1;
        ir_load = 1'b1;
      end
      ST_MOV: begin
        rd_idx = flds.rd;
        rd_wr  = 1'b1;
        if (flds.imm_form) begin
          rf_src  = SRC_IMM;
          imm_val = mov_ext;
        end else begin
          rf_src = SRC_REG;
          rm_idx = flds.rm;
        end
      end
      ST_LOAD: begin
        rf_src = SRC_RAM;
        rd_idx = flds.rd;
        rm_idx = flds.rm;
        rd_wr  = 1'b1;
      end
      ST_STORE: begin
        ram_wr = 1'b1;
        rm_idx = flds.rm;
        if (flds.imm_form) begin
          ram_addr_sel = 1'b1;
          imm_val      = str_ext;
        end else begin
          rn_idx = flds.rn;
        end
      end
      ST_ALU: begin
        rf_src = SRC_ALU;
        rd_idx = flds.rd;
        rm_idx = flds.rm;
        rn_idx = flds.rn;
        rd_wr  = 1'b1;
        alu_op = flds.op;
      end
      default: ;
    endcase
  end

  // R9
  store_noregwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_wr |-> !rd_wr);
  // R11
  alu_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_op != '0) |-> (rf_src == SRC_ALU && rd_wr));
  // R6
  imm_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_src == SRC_IMM && rd_wr) |-> imm_val[DATA_W-1:IMM8_W] == '0);
  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pc_clear, pc_step, ram_wr, rd_wr}));
endmodule

// File: rtl/cpu_ctrl_fsm.sv
module cpu_ctrl_fsm
  import cpu_ctrl_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] instr,
  output logic [3:0]         state_code,
  output logic               pc_clear,
  output logic               pc_step,
  output logic               rom_rd,
  output logic               ir_load,
  output logic [DATA_W-1:0]  imm_val,
  output logic               ram_addr_sel,
  output logic               ram_wr,
  output logic [1:0]         rf_src,
  output logic [2:0]         rd_idx,
  output logic               rd_wr,
  output logic [2:0]         rm_idx,
  output logic [2:0]         rn_idx,
  output logic [3:0]         alu_op
);
  fields_t flds;
  state_e  state;

  cpu_ctrl_fields #(.INSTR_W(INSTR_W)) u_fields (
    .instr (instr),
    .flds  (flds)
  );

  cpu_ctrl_next u_next (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (flds.op),
    .state (state)
  );

  cpu_ctrl_outputs #(.DATA_W(DATA_W)) u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (state),
    .flds         (flds),
    .pc_clear     (pc_clear),
    .pc_step      (pc_step),
    .rom_rd       (rom_rd),
    .ir_load      (ir_load),
    .imm_val      (imm_val),
    .ram_addr_sel (ram_addr_sel),
    .ram_wr       (ram_wr),
    .rf_src       (rf_src),
    .rd_idx       (rd_idx),
    .rd_wr        (rd_wr),
    .rm_idx       (rm_idx),
    .rn_idx       (rn_idx),
    .alu_op       (alu_op)
  );

  assign state_code = state;
endmodule

// File: tb/cpu_ctrl_fsm_tb.sv
module cpu_ctrl_fsm_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic [3:0]  state_code;
  logic        pc_clear, pc_step, rom_rd, ir_load, ram_addr_sel, ram_wr, rd_wr;
  logic [15:0] imm_val;
  logic [1:0]  rf_src;
  logic [2:0]  rd_idx, rm_idx, rn_idx;
  logic [3:0]  alu_op;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10ns clk = ~clk;

  cpu_ctrl_fsm u_dut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .state_code(state_code),
    .pc_clear(pc_clear), .pc_step(pc_step), .rom_rd(rom_rd), .ir_load(ir_load),
    .imm_val(imm_val), .ram_addr_sel(ram_addr_sel), .ram_wr(ram_wr),
    .rf_src(rf_src), .rd_idx(rd_idx), .rd_wr(rd_wr), .rm_idx(rm_idx),
    .rn_idx(rn_idx), .alu_op(alu_op)
  );

  function automatic logic [41:0] got_vec();
    return {state_code, pc_clear, pc_step, rom_rd, ir_load, imm_val, ram_addr_sel,
            ram_wr, rf_src, rd_idx, rd_wr, rm_idx, rn_idx, alu_op};
  endfunction

  // expected outputs per state, written from the requirement text
  function automatic logic [41:0] exp_vec(logic [3:0] st, logic [15:0] w);
    logic pcc = 0, pcs = 0, rom = 0, irl = 0, rs = 0, rw = 0, rdw = 0;
    logic [15:0] im = '0;
    logic [1:0] src = 2'b00;
    logic [2:0] rd = '0, rm = '0, rn = '0;
    logic [3:0] alu = '0;
    case (st)
      4'b0000: pcc = 1;                                   // R1
      4'b0001: begin pcs = 1; rom = 1; irl = 1; end       // R2
      4'b0101: begin                                      // R6 / R7
        rdw = 1; rd = w[10:8];
        if (w[11]) begin src = 2'b10; im = {8'h00, w[7:0]}; end
        else rm = w[7:5];
      end
      4'b0110: begin src = 2'b01; rdw = 1; rd = w[10:8]; rm = w[7:5]; end // R8
      4'b0111: begin                                      // R9 / R10
        rw = 1; rm = w[7:5];
        if (w[11]) begin rs = 1; im = {8'h00, w[10:8], w[4:0]}; end
        else rn = w[4:2];
      end
      4'b1000: begin                                      // R11
        src = 2'b11; rdw = 1; rd = w[10:8]; rm = w[7:5]; rn = w[4:2]; alu = w[15:12];
      end
      default: ;                                          // R3, R5
    endcase
    return {st, pcc, pcs, rom, irl, im, rs, rw, src, rd, rdw, rm, rn, alu};
  endfunction

  function automatic string req_of(logic [3:0] st, logic [15:0] w);
    case (st)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0011: return "R3";
      4'b0100: return "R5";
      4'b0101: return w[11] ? "R6" : "R7";
      4'b0110: return "R8";
      4'b0111: return w[11] ? "R9" : "R10";
      4'b1000: return "R11";
      default: return "R4";
    endcase
  endfunction

  // R4: decode target from opcode
  function automatic logic [3:0] exec_of(logic [3:0] op);
    if (op == 4'hF) return 4'b0100;
    if (op == 4'h1) return 4'b0101;
    if (op == 4'h2) return 4'b0111;
    if (op == 4'h3) return 4'b0110;
    if (op >= 4'h4 && op <= 4'hA) return 4'b1000;
    return 4'b0001;
  endfunction

  task automatic check_vec(string req, logic [15:0] w, logic [3:0] st);
    logic [41:0] e = exp_vec(st, w);
    logic [41:0] g = got_vec();
    checks++;
    if (g !== e) begin
      errors++;
      $display("FAIL %s instr=%h actual=%h expected=%h", req, w, g, e);
    end
  endtask

  task automatic check_state(string req, logic [15:0] w, logic [3:0] st);
    checks++;
    if (state_code !== st) begin
      errors++;
      $display("FAIL %s instr=%h state actual=%b expected=%b", req, w, state_code, st);
    end
  endtask

  task automatic run_one(logic [15:0] w);
    logic [3:0] ex = exec_of(w[15:12]);
    logic [3:0] after;
    instr = w;
    rst_n = 1'b0;
    @(negedge clk);
    check_vec("R1", w, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check_vec("R2", w, 4'b0001);
    @(negedge clk);
    check_vec("R3", w, 4'b0011);
    @(negedge clk);
    check_state("R4", w, ex);
    check_vec(req_of(ex, w), w, ex);
    @(negedge clk);
    if (ex == 4'b0100) begin
      check_vec("R5", w, 4'b0100);
      @(negedge clk);
      check_vec("R5", w, 4'b0100);
    end else begin
      after = (ex == 4'b0001) ? 4'b0011 : 4'b0001;
      check_state("R12", w, after);
      check_vec(req_of(after, w), w, after);
    end
  endtask

  initial begin
    logic [10:0] pats [5] = '{11'h000, 11'h7FF, 11'h555, 11'h2AA, 11'h1C9};
    @(negedge clk);
    for (int op = 0; op < 16; op++)
      for (int f = 0; f < 2; f++)
        for (int p = 0; p < 5; p++)
          run_one({op[3:0], f[0], pats[p] ^ {8'h00, f[0], 2'b00}});
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule